// File: doc/BRIEF.md
# Vertical Sync Extractor

This block watches a digital, active-low composite sync stream that an analog front end has already clamped and sliced. The stream is sampled on a fixed system clock. For each sync pulse the block counts how many samples the line stays low and how far apart consecutive falling edges are. From these two numbers it picks out three kinds of pulse: the short pulses that come at half-line spacing at the top of a field, the long serration pulses that follow them, and ordinary line sync. From that it produces one active-low vertical sync pulse per field.

The pulse starts on the first serration pulse's rising edge. When the half-line-spaced short pulses are not followed by any serration pulse, a fallback timer fires the output a fixed time after the last of their falling edges. The output then stays low for a parameterised number of half lines. After firing, the block ignores all further serration and half-spaced pulses. It arms again only when a short pulse arrives at full-line spacing. All timing is set in clock cycles derived from a clock-rate parameter.

Top module: `vsync_extract`

Terms used below:
- HALF = CLK_HZ/(2*LINE_HZ) clock cycles.
- Low count: the number of consecutive clock samples at which csync_n is 0.
- Spacing: the number of cycles between the samples of two consecutive falling edges.
- Half-spaced: a pulse whose spacing is below 3*HALF/2.

## Requirements
- R1: While rst_n is low, vsync_n is 1, including when reset arrives in the middle of an output pulse. After reset is released, vsync_n stays 1, the block is armed, and the spacing tracker behaves as if no edge had been seen.
- R2: A pulse with a low count below HALF/4 is short. A half-spaced short pulse seen while armed starts the pre-equalizing phase. A low count of exactly HALF/4 is not short and changes nothing.
- R3: A pulse with a low count above HALF/2 is broad. Low counts from HALF/4 to HALF/2 inclusive are ignored and produce no output. A broad pulse seen while armed fires the output.
- R4: In the first clock sample where csync_n is 1 after a broad pulse, the firing is decided. vsync_n goes to 0 on the second rising clock edge after that sample.
- R5: In the pre-equalizing phase, vsync_n goes to 0 on clock edge TOUT+1 after the last falling edge was sampled, if no further falling edge has arrived by then. TOUT = (CLK_HZ/1000)*TOUT_US/1000 cycles.
- R6: Each output pulse keeps vsync_n at 0 for exactly VS_HALVES*HALF clock cycles and then returns it to 1.
- R7: After firing, broad and half-spaced short pulses produce no further output. The block is armed again by the first short pulse that is not half-spaced.
- R8: A stream made only of short pulses at full-line spacing never drives vsync_n to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the sync stream |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the block on the clock |
| csync_n | input | 1 | Sliced composite sync, low during sync tips, synchronous to clk |
| vsync_n | output | 1 | Vertical sync, low for one pulse per field |

## Verification
The bench builds the block with CLK_HZ = 1,000,000, LINE_HZ = 15,625 and TOUT_US = 60. With these values a half line is 32 cycles, the class thresholds are 8 and 16, the fallback timer is 60 cycles and the output pulse is 96 cycles. Every class boundary (7 against 8 low samples, 16 against 17) and a whole field take only a few hundred cycles to reach. The 60-cycle timeout sits between half-line spacing (32) and line spacing (64), as it does at full rate. This lets the fallback be checked to the exact cycle against both kinds of spacing.

// File: rtl/vsx_pkg.sv
package vsx_pkg;

  // Width class of one completed sync pulse
  typedef enum logic [1:0] {
    CLS_SHORT = 2'd0,
    CLS_MID   = 2'd1,
    CLS_BROAD = 2'd2
  } cls_e;

  // Field phase tracker state
  typedef enum logic [1:0] {
    PH_ARMED    = 2'd0,
    PH_PREEQ    = 2'd1,
    PH_DISARMED = 2'd2
  } phase_e;

endpackage

// File: rtl/vsx_rst_sync.sv
module vsx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = shift_q[STAGES-1];

endmodule

// File: rtl/vsx_pulse_meter.sv
module vsx_pulse_meter
  import vsx_pkg::*;
#(
  parameter int unsigned EQ_MAX    = 8,
  parameter int unsigned SER_MIN   = 16,
  parameter int unsigned SPACE_MAX = 48,
  parameter int unsigned SINCE_MAX = 60,
  localparam int unsigned LOW_SAT  = SER_MIN + 1,
  localparam int unsigned LW       = $clog2(LOW_SAT + 1),
  localparam int unsigned SW       = $clog2(SINCE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          csync_n,
  output logic          cls_vld,
  output cls_e          cls,
  output logic          half_sp,
  output logic [SW-1:0] since
);

  logic          in_q;
  logic [LW-1:0] low_q,   low_d;
  logic [SW-1:0] since_q, since_d;
  logic          half_q,  half_d;
  logic          vld_q,   vld_d;
  cls_e          cls_q,   cls_d;
  logic          fall, rise;

  assign fall = in_q  & ~csync_n;
  assign rise = ~in_q &  csync_n;

  // Next-state: low-sample count, time since last fall, spacing flag, class
  always_comb begin
    low_d   = low_q;
    since_d = since_q;
    half_d  = half_q;
    vld_d   = rise;
    cls_d   = cls_q;

    if (fall)                                   low_d = LW'(1);
    else if (!csync_n && low_q != LW'(LOW_SAT)) low_d = low_q + LW'(1);

    if (fall) begin
      since_d = '0;
      half_d  = (since_q < SW'(SPACE_MAX - 1));
    end else if (since_q != SW'(SINCE_MAX)) begin
      since_d = since_q + SW'(1);
    end

    if (rise) begin
      if (low_q < LW'(EQ_MAX))       cls_d = CLS_SHORT;
      else if (low_q > LW'(SER_MIN)) cls_d = CLS_BROAD;
      else                           cls_d = CLS_MID;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      in_q    <= 1'b1;
      low_q   <= '0;
      since_q <= SW'(SINCE_MAX);
      half_q  <= 1'b0;
      vld_q   <= 1'b0;
      cls_q   <= CLS_MID;
    end else begin
      in_q    <= csync_n;
      low_q   <= low_d;
      since_q <= since_d;
      half_q  <= half_d;
      vld_q   <= vld_d;
      cls_q   <= cls_d;
    end
  end

  assign cls_vld = vld_q;
  assign cls     = cls_q;
  assign half_sp = half_q;
  assign since   = since_q;

endmodule

// File: rtl/vsx_phase_ctl.sv
module vsx_phase_ctl
  import vsx_pkg::*;
#(
  parameter int unsigned SW       = 6,
  parameter int unsigned TOUT_CYC = 60
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          cls_vld,
  input  cls_e          cls,
  input  logic          half_sp,
  input  logic [SW-1:0] since,
  output logic          fire,
  output phase_e        state
);

  phase_e st_q, st_d;
  logic   broad_seen, short_half, short_full, timed_out;

  assign broad_seen = cls_vld && (cls == CLS_BROAD);
  assign short_half = cls_vld && (cls == CLS_SHORT) &&  half_sp;
  assign short_full = cls_vld && (cls == CLS_SHORT) && !half_sp;
  assign timed_out  = (since >= SW'(TOUT_CYC));

  always_comb begin
    st_d = st_q;
    fire = 1'b0;
    case (st_q)
      PH_ARMED: begin
        if (broad_seen)      fire = 1'b1;
        else if (short_half) st_d = PH_PREEQ;
      end
      PH_PREEQ: begin
        if (broad_seen || timed_out) fire = 1'b1;
      end
      PH_DISARMED: begin
        if (short_full) st_d = PH_ARMED;
      end
      default: st_d = PH_ARMED;
    endcase
    if (fire) st_d = PH_DISARMED;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_q <= PH_ARMED;
    else         st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/vsx_vs_gen.sv
module vsx_vs_gen #(
  parameter int unsigned VS_W = 96,
  localparam int unsigned VW  = $clog2(VS_W + 1)
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic fire,
  output logic vsync_n
);

  logic [VW-1:0] rem_q, rem_d;
  logic          vs_q,  vs_d;

  always_comb begin
    rem_d = rem_q;
    vs_d  = vs_q;
    if (fire) begin
      vs_d  = 1'b0;
      rem_d = VW'(VS_W - 1);
    end else if (!vs_q) begin
      if (rem_q == '0) vs_d  = 1'b1;
      else             rem_d = rem_q - VW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rem_q <= '0;
      vs_q  <= 1'b1;
    end else begin
      rem_q <= rem_d;
      vs_q  <= vs_d;
    end
  end

  assign vsync_n = vs_q;

endmodule

// File: rtl/vsync_extract.sv
module vsync_extract
  import vsx_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 27_000_000,
  parameter int unsigned LINE_HZ    = 15_734,
  parameter int unsigned TOUT_US    = 60,
  parameter int unsigned VS_HALVES  = 3,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  output logic vsync_n
);

  localparam int unsigned HALF_CYC  = CLK_HZ / (2 * LINE_HZ);
  localparam int unsigned EQ_MAX    = HALF_CYC / 4;
  localparam int unsigned SER_MIN   = HALF_CYC / 2;
  localparam int unsigned SPACE_MAX = (HALF_CYC * 3) / 2;
  localparam int unsigned TOUT_CYC  = (CLK_HZ / 1000) * TOUT_US / 1000;
  localparam int unsigned VS_W      = VS_HALVES * HALF_CYC;
  localparam int unsigned SINCE_MAX = (TOUT_CYC > SPACE_MAX) ? TOUT_CYC : SPACE_MAX;
  localparam int unsigned SW        = $clog2(SINCE_MAX + 1);

  logic          rst_sn;
  logic          cls_vld;
  cls_e          cls;
  logic          half_sp;
  logic [SW-1:0] since;
  logic          fire;
  phase_e        state;

  vsx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  vsx_pulse_meter #(
    .EQ_MAX    (EQ_MAX),
    .SER_MIN   (SER_MIN),
    .SPACE_MAX (SPACE_MAX),
    .SINCE_MAX (SINCE_MAX)
  ) u_meter (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .csync_n (csync_n),
    .cls_vld (cls_vld),
    .cls     (cls),
    .half_sp (half_sp),
    .since   (since)
  );

  vsx_phase_ctl #(
    .SW       (SW),
    .TOUT_CYC (TOUT_CYC)
  ) u_phase (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .cls_vld (cls_vld),
    .cls     (cls),
    .half_sp (half_sp),
    .since   (since),
    .fire    (fire),
    .state   (state)
  );

  vsx_vs_gen #(.VS_W(VS_W)) u_gen (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .fire    (fire),
    .vsync_n (vsync_n)
  );

endmodule

// File: rtl/vsx_checker.sv
module vsx_checker
  import vsx_pkg::*;
#(
  parameter int unsigned VS_W     = 96,
  parameter int unsigned TOUT_CYC = 60,
  parameter int unsigned SW       = 6,
  localparam int unsigned VW      = $clog2(VS_W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vsync_n,
  input logic          cls_vld,
  input cls_e          cls,
  input logic          half_sp,
  input logic [SW-1:0] since,
  input phase_e        state
);

  logic [VW-1:0] low_run;
  logic          seen_norm, fired_once;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run    <= '0;
      seen_norm  <= 1'b0;
      fired_once <= 1'b0;
    end else begin
      if (vsync_n)                   low_run <= '0;
      else if (low_run != VW'(VS_W)) low_run <= low_run + VW'(1);
      if (!vsync_n && low_run == '0) begin
        seen_norm  <= 1'b0;
        fired_once <= 1'b1;
      end else if (cls_vld && cls == CLS_SHORT && !half_sp) begin
        seen_norm <= 1'b1;
      end
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> vsync_n);

  // R3: a mid-width pulse leaves the phase untouched
  assert_mid_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_vld && cls == CLS_MID && since < SW'(TOUT_CYC)) |=> (state == $past(state)));

  // R4 / R5: every output pulse has a broad pulse or an expired timer as its cause
  assert_launch_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> ($past(cls_vld && cls == CLS_BROAD) || $past(since >= SW'(TOUT_CYC))));

  assert_width_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> (low_run < VW'(VS_W)));

  assert_width_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> (low_run == VW'(VS_W)));

  assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> (!fired_once || seen_norm));

endmodule

bind vsync_extract vsx_checker #(
  .VS_W     (VS_W),
  .TOUT_CYC (TOUT_CYC),
  .SW       (SW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .vsync_n (vsync_n),
  .cls_vld (cls_vld),
  .cls     (cls),
  .half_sp (half_sp),
  .since   (since),
  .state   (state)
);

// File: tb/tb_vsync_extract.sv
module tb_vsync_extract;

  localparam int CLK_HZ  = 1_000_000;
  localparam int LINE_HZ = 15_625;
  localparam int TOUT_US = 60;
  localparam int HALF    = CLK_HZ / (2 * LINE_HZ);   // 32
  localparam int TOUT    = (CLK_HZ / 1000) * TOUT_US / 1000;  // 60
  localparam int VS_W    = 3 * HALF;                 // 96
  localparam int BROAD_L = 27;

  logic clk = 1'b0;
  logic rst_n;
  logic csync_n;
  logic vsync_n;

  int checks = 0;
  int fails  = 0;
  int falls  = 0;
  logic vs_prev = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vsync_extract #(
    .CLK_HZ  (CLK_HZ),
    .LINE_HZ (LINE_HZ),
    .TOUT_US (TOUT_US)
  ) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .csync_n (csync_n),
    .vsync_n (vsync_n)
  );

  // Count output pulses (pre-edge values at each rising edge)
  always @(posedge clk) begin
    if (vs_prev && !vsync_n) falls = falls + 1;
    vs_prev = vsync_n;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int low, input int period);
    @(negedge clk);
    csync_n = 1'b0;
    repeat (low) @(negedge clk);
    csync_n = 1'b1;
    repeat (period - low - 1) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at the first negedge with vsync_n low; returns the low length
  task automatic measure_width(output int w);
    w = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (vsync_n) break;
      w++;
    end
  endtask

  task automatic rearm();
    pulse(4, 2 * HALF);
    pulse(4, 2 * HALF);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    csync_n = 1'b1;
    idle(4);
    check(vsync_n == 1'b1, "R1 output high in reset", vsync_n, 1);
    rst_n = 1'b1;
    idle(6);
    check(vsync_n == 1'b1, "R1 output high after release", vsync_n, 1);
  endtask

  task automatic t_normal_lines();
    int f0 = falls;
    for (int i = 0; i < 8; i++) pulse(4, 2 * HALF);
    idle(10);
    check(falls == f0, "R8 line sync alone gives no vsync", falls - f0, 0);
    check(vsync_n == 1'b1, "R8 output idle", vsync_n, 1);
  endtask

  task automatic t_field_serration();
    int f0 = falls;
    int w;
    rearm();
    for (int i = 0; i < 6; i++) pulse(2, HALF);
    @(negedge clk);
    csync_n = 1'b0;
    repeat (BROAD_L) @(negedge clk);
    csync_n = 1'b1;
    @(negedge clk);
    check(vsync_n == 1'b1, "R4 not yet low one edge after rise", vsync_n, 1);
    @(negedge clk);
    check(vsync_n == 1'b0, "R4 low on second edge after rise", vsync_n, 0);
    measure_width(w);
    check(w == VS_W, "R6 serration-launched width", w, VS_W);
    for (int i = 0; i < 5; i++) pulse(BROAD_L, HALF);
    for (int i = 0; i < 6; i++) pulse(2, HALF);
    idle(20);
    check(falls - f0 == 1, "R7 no second pulse in same interval", falls - f0, 1);
    for (int i = 0; i < 3; i++) pulse(4, 2 * HALF);
    for (int i = 0; i < 6; i++) pulse(2, HALF);
    pulse(BROAD_L, HALF);
    idle(150);
    check(falls - f0 == 2, "R7 re-armed by full-spaced line sync", falls - f0, 2);
  endtask

  task automatic t_timeout();
    bit early = 1'b0;
    int w;
    rearm();
    for (int i = 0; i < 5; i++) pulse(2, HALF);
    @(negedge clk);
    csync_n = 1'b0;
    for (int k = 1; k <= TOUT + 1; k++) begin
      @(negedge clk);
      if (!vsync_n) early = 1'b1;
      if (k == 2) csync_n = 1'b1;
    end
    check(early == 1'b0, "R5 no output before timeout", early, 0);
    @(negedge clk);
    check(vsync_n == 1'b0, "R5 forced output at timeout", vsync_n, 0);
    measure_width(w);
    check(w == VS_W, "R6 timeout-launched width", w, VS_W);
  endtask

  task automatic t_classify();
    int f0;
    rearm();
    f0 = falls;
    pulse(EQ_LIM, HALF);
    pulse(EQ_LIM, HALF);
    idle(100);
    check(falls == f0, "R2 low count of HALF/4 is not short", falls - f0, 0);
    rearm();
    f0 = falls;
    pulse(EQ_LIM - 1, HALF);
    pulse(EQ_LIM - 1, HALF);
    idle(200);
    check(falls - f0 == 1, "R2 low count below HALF/4 enters pre-equalizing", falls - f0, 1);
    rearm();
    f0 = falls;
    pulse(SER_LIM, 2 * HALF);
    idle(100);
    check(falls == f0, "R3 low count of HALF/2 ignored", falls - f0, 0);
    pulse(SER_LIM + 1, 2 * HALF);
    idle(150);
    check(falls - f0 == 1, "R3 low count above HALF/2 fires", falls - f0, 1);
  endtask

  localparam int EQ_LIM  = HALF / 4;   // 8
  localparam int SER_LIM = HALF / 2;   // 16

  task automatic t_reset_mid();
    int f0;
    rearm();
    @(negedge clk);
    csync_n = 1'b0;
    repeat (20) @(negedge clk);
    csync_n = 1'b1;
    idle(2);
    check(vsync_n == 1'b0, "R1 pulse running before reset", vsync_n, 0);
    idle(5);
    rst_n = 1'b0;
    #1;
    check(vsync_n == 1'b1, "R1 reset forces output high mid-pulse", vsync_n, 1);
    idle(3);
    rst_n = 1'b1;
    idle(5);
    check(vsync_n == 1'b1, "R1 output high after mid-pulse reset", vsync_n, 1);
    f0 = falls;
    pulse(20, 2 * HALF);
    idle(150);
    check(falls - f0 == 1, "R1 armed after reset", falls - f0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    csync_n = 1'b1;
    t_reset();
    t_normal_lines();
    t_field_serration();
    t_timeout();
    t_classify();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule